// File: doc/BRIEF.md
# Programmable Interrupt Controller Core

This block arbitrates eight interrupt request lines for one processor. Software sets it up through a byte-wide register port. The port has one address bit, a write strobe and a read strobe. The setup is a short chain of set-up words. After the chain, software sends run-time command words that control end-of-interrupt handling, priority rotation, the special mask and the readback source. The block keeps three registers: a request register, an in-service register and a mask register. It compares the best unmasked request against the best level in service, and it raises `intr` when the request outranks that level.

When the processor pulses `ack` for one cycle, the block drives `vector` in that same cycle. The vector is a five-bit base from setup with the serviced level in its low three bits. At the clock edge that ends the acknowledge, the block updates its registers. Software can also poll. In that case a read returns the pending level code, and the read takes the place of an acknowledge.

The register port has no back-pressure. A strobe is taken on the rising clock edge where it is high, and every strobe is accepted. `rdata` and `vector` are combinational and are valid while `rd` or `ack` is high. `irq_in` must already be synchronous to `clk`.

Top module: `irq_ctrl_core`

## Requirements
- R1: Reset and restart put the block in a known state. Reset leaves it idle and waiting for setup, with `intr` low. A restart is a write at address 0 with data bit 4 set, and it takes effect at any time. It clears the mask, in-service, request, special-mask and poll state. It also makes the request register the readback source and sets fixed priority, with level 0 highest.
- R2: The words after a restart go to address 1 in this order:
  - the base word, whose bits 7:3 become vector bits 7:3;
  - a cascade word, only if restart bit 1 was 0; its content is not kept;
  - a mode word, only if restart bit 0 was 1.
  Until the last expected word arrives, `intr` stays low, acknowledges are ignored, other address-0 writes are ignored, and address-1 writes do not reach the mask.
- R3: Once setup is complete, a write at address 1 loads the mask register, and a read at address 1 returns it. A 1 in a mask bit blocks that level.
- R4: Restart bit 3 sets the trigger mode. With bit 3 = 0 (edge), a low-to-high input transition sets the request bit, and the bit stays set until that level is serviced. With bit 3 = 1 (level), the request register follows the inputs one cycle later. In both modes the request register records requests whether or not they are masked.
- R5: `intr` is high exactly when two conditions hold. First, an unmasked request is pending. Second, the best such request ranks strictly above the best level in service. Rank counts down from the current lead level, modulo 8.
- R6: During a one-cycle `ack`, if `intr` is high, `vector` is {base, level}. At the closing edge, that level's in-service bit is set, and in edge mode its request bit is cleared. If `intr` is low, `vector` is {base, 3'b111} and nothing else changes.
- R7: Command writes at address 0 with data bits 4:3 = 00 handle end of interrupt. With bit 5 = 1 and bit 6 = 0, the best-ranked in-service bit is cleared. With bits 6:5 = 11, the in-service bit named by bits 2:0 is cleared.
- R8: In the same command, bit 7 = 1 together with an end of interrupt makes the cleared level lowest, so the lead level becomes that level + 1. Bits 7:5 = 110 make the level in bits 2:0 lowest without clearing anything.
- R9: Mode-word bit 1 selects automatic end of interrupt. In that mode an acknowledge does not leave the in-service bit set. An end-of-interrupt command with bits 6:5 = 00 stores bit 7 as an auto-rotate flag. While that flag is set, each automatic acknowledge makes the serviced level lowest.
- R10: Command writes at address 0 with bits 4:3 = 01 choose the address-0 readback source. Bits 1:0 = 10 select the request register, and 11 selects the in-service register. With bit 1 = 0 the choice is left unchanged. The choice holds until it is changed.
- R11: In that command, bit 2 = 1 makes the next address-0 read return {flag, 4'b0, level}. The flag is the `intr` condition, and the level field is 0 when the flag is clear. A poll read with the flag set is handled as an acknowledge of that level.
- R12: In that command, bits 6:5 = 11 turn the special mask on and 10 turns it off. While the special mask is on, in-service levels whose mask bit is set are left out of the R5 comparison.
- R13: Mode-word bit 4 selects special fully nested operation. In that mode a request at the same level as the best in-service level also raises `intr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Register port address bit |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one per accepted word |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data, combinational while `rd` is high |
| irq_in | input | 8 | Interrupt request inputs, synchronous |
| intr | output | 1 | Interrupt request to the processor |
| ack | input | 1 | One-cycle interrupt acknowledge |
| vector | output | 8 | Vector, valid while `ack` is high |

## Verification
The hardest state to reach from the ports has two nested levels in service and a lower-ranked request pending behind them. A masked in-service level must then be lifted out of the comparison by the special mask. The bench builds this state with staggered rising edges on the inputs and acknowledges them before any end of interrupt. It then clears the levels one at a time and checks `intr` after each step. Rotation is driven through a full wrap of the lead level, using rotating end-of-interrupt, set-priority and automatic rotation in turn. Every request pattern and every mask value is swept, and the expected level is computed as the lowest set bit.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int NUM_LVL = 8;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_BASE,
    SEQ_CASC,
    SEQ_MODE,
    SEQ_RUN
  } seq_st_t;

  typedef enum logic {
    SRC_REQ = 1'b0,
    SRC_SRV = 1'b1
  } rd_src_t;
endpackage

// File: rtl/irq_prio.sv
`timescale 1ns/1ps
// Rotating priority resolver: finds the best-ranked set bit, counting from lead.
module irq_prio #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] lead,
  output logic          any,
  output logic [LW-1:0] lvl
);
  logic [N-1:0]  rot;
  logic [LW-1:0] off;

  for (genvar k = 0; k < N; k++) begin : g_rot
    logic [LW-1:0] idx;
    assign idx    = lead + LW'(k);
    assign rot[k] = req[idx];
  end

  always_comb begin
    off = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (rot[k]) off = LW'(k);
    end
  end

  assign any = |req;
  assign lvl = off + lead;
endmodule

// File: rtl/irq_req.sv
`timescale 1ns/1ps
// Request register with edge or level capture.
module irq_req #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_in,
  input  logic         level_mode,
  input  logic         restart,
  input  logic [N-1:0] clr,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev_q;
  logic [N-1:0] irr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_in;
      if (restart)         irr_q <= '0;
      else if (level_mode) irr_q <= irq_in;
      else                 irr_q <= (irr_q & ~clr) | (irq_in & ~prev_q);
    end
  end

  assign irr = irr_q;
endmodule

// File: rtl/irq_prog.sv
`timescale 1ns/1ps
// Setup-word sequencer, run-time command decode and configuration state.
module irq_prog
  import irq_pkg::*;
#(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr,
  input  logic [N-1:0]    wdata,
  input  logic            wr,
  input  logic            rd,
  output logic            restart,
  output logic            running,
  output logic            ltim,
  output logic            aeoi,
  output logic            sfnm,
  output logic [N-1:0]    mask,
  output logic [N-LW-1:0] base,
  output logic            smm,
  output rd_src_t         rsel,
  output logic            poll,
  output logic            aeoi_rot,
  output logic            eoi_ns,
  output logic            eoi_sp,
  output logic            rot,
  output logic            setpri,
  output logic [LW-1:0]   cmd_lvl
);
  seq_st_t st_q;
  logic    single_q, need4_q;
  logic    wr0, wr1, op2, op3;

  assign wr0     = wr & ~addr;
  assign wr1     = wr & addr;
  assign restart = wr0 & wdata[4];
  assign running = (st_q == SEQ_RUN);
  assign op2     = wr0 & running & (wdata[4:3] == 2'b00);
  assign op3     = wr0 & running & (wdata[4:3] == 2'b01);

  assign eoi_ns  = op2 & wdata[5] & ~wdata[6];
  assign eoi_sp  = op2 & wdata[5] & wdata[6];
  assign rot     = op2 & wdata[7] & wdata[5];
  assign setpri  = op2 & wdata[7] & wdata[6] & ~wdata[5];
  assign cmd_lvl = wdata[LW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SEQ_IDLE;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
      ltim     <= 1'b0;
      aeoi     <= 1'b0;
      sfnm     <= 1'b0;
      mask     <= '0;
      base     <= '0;
      smm      <= 1'b0;
      rsel     <= SRC_REQ;
      poll     <= 1'b0;
      aeoi_rot <= 1'b0;
    end else if (restart) begin
      st_q     <= SEQ_BASE;
      ltim     <= wdata[3];
      single_q <= wdata[1];
      need4_q  <= wdata[0];
      aeoi     <= 1'b0;
      sfnm     <= 1'b0;
      mask     <= '0;
      smm      <= 1'b0;
      rsel     <= SRC_REQ;
      poll     <= 1'b0;
      aeoi_rot <= 1'b0;
    end else begin
      unique case (st_q)
        SEQ_BASE: if (wr1) begin
          base <= wdata[N-1:LW];
          if (!single_q)    st_q <= SEQ_CASC;
          else if (need4_q) st_q <= SEQ_MODE;
          else              st_q <= SEQ_RUN;
        end
        SEQ_CASC: if (wr1) st_q <= need4_q ? SEQ_MODE : SEQ_RUN;
        SEQ_MODE: if (wr1) begin
          aeoi <= wdata[1];
          sfnm <= wdata[4];
          st_q <= SEQ_RUN;
        end
        SEQ_RUN:  if (wr1) mask <= wdata;
        default: ;
      endcase

      if (op2 && wdata[6:5] == 2'b00) aeoi_rot <= wdata[7];

      if (op3) begin
        if (wdata[1]) rsel <= wdata[0] ? SRC_SRV : SRC_REQ;
        if (wdata[6]) smm  <= wdata[5];
        if (wdata[2]) poll <= 1'b1;
      end else if (rd && !addr) begin
        poll <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_core.sv
`timescale 1ns/1ps
// Eight-level programmable interrupt controller, top level.
module irq_ctrl_core
  import irq_pkg::*;
#(
  parameter int N  = NUM_LVL,
  parameter int LW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         addr,
  input  logic [N-1:0] wdata,
  input  logic         wr,
  input  logic         rd,
  output logic [N-1:0] rdata,
  input  logic [N-1:0] irq_in,
  output logic         intr,
  input  logic         ack,
  output logic [N-1:0] vector
);
  logic            restart, running, ltim, aeoi, sfnm, smm, poll, aeoi_rot;
  logic            eoi_ns, eoi_sp, rot, setpri;
  logic [LW-1:0]   cmd_lvl;
  logic [N-1:0]    mask_q, irr, isr_q;
  logic [N-LW-1:0] base;
  rd_src_t         rsel;

  logic [LW-1:0]   lead_q;
  logic [N-1:0]    pend, isr_eff, one_p, one_h, one_c, isr_set, isr_clr, irr_clr;
  logic            p_any, s_any, h_any;
  logic [LW-1:0]   p_lvl, s_lvl, h_lvl, rank_p, rank_s;
  logic            beats, ack_ok, ack_hit, poll_rd, svc;

  irq_prog #(.N(N), .LW(LW)) u_prog (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .restart(restart), .running(running), .ltim(ltim), .aeoi(aeoi), .sfnm(sfnm),
    .mask(mask_q), .base(base), .smm(smm), .rsel(rsel), .poll(poll),
    .aeoi_rot(aeoi_rot), .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .rot(rot),
    .setpri(setpri), .cmd_lvl(cmd_lvl)
  );

  irq_req #(.N(N)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .level_mode(ltim),
    .restart(restart), .clr(irr_clr), .irr(irr)
  );

  assign pend    = irr & ~mask_q;
  assign isr_eff = smm ? (isr_q & ~mask_q) : isr_q;

  irq_prio #(.N(N), .LW(LW)) u_pend (.req(pend),    .lead(lead_q), .any(p_any), .lvl(p_lvl));
  irq_prio #(.N(N), .LW(LW)) u_eff  (.req(isr_eff), .lead(lead_q), .any(s_any), .lvl(s_lvl));
  irq_prio #(.N(N), .LW(LW)) u_high (.req(isr_q),   .lead(lead_q), .any(h_any), .lvl(h_lvl));

  assign rank_p = p_lvl - lead_q;
  assign rank_s = s_lvl - lead_q;
  assign beats  = p_any & (~s_any | (rank_p < rank_s) | (sfnm & (p_lvl == s_lvl)));
  assign intr   = running & beats;

  assign ack_ok  = ack & running;
  assign ack_hit = ack_ok & beats;
  assign poll_rd = rd & ~addr & poll & running;
  assign svc     = (ack_ok | poll_rd) & beats;

  assign one_p = {{(N-1){1'b0}}, 1'b1} << p_lvl;
  assign one_h = {{(N-1){1'b0}}, 1'b1} << h_lvl;
  assign one_c = {{(N-1){1'b0}}, 1'b1} << cmd_lvl;

  assign irr_clr = (svc & ~ltim) ? one_p : '0;
  assign isr_set = (svc & ~aeoi) ? one_p : '0;

  always_comb begin
    isr_clr = '0;
    if (eoi_ns && h_any) isr_clr = one_h;
    else if (eoi_sp)     isr_clr = one_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q  <= '0;
      lead_q <= '0;
    end else if (restart) begin
      isr_q  <= '0;
      lead_q <= '0;
    end else begin
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      if (rot && eoi_ns && h_any)       lead_q <= h_lvl + LW'(1);
      else if (rot && eoi_sp)           lead_q <= cmd_lvl + LW'(1);
      else if (setpri)                  lead_q <= cmd_lvl + LW'(1);
      else if (svc && aeoi && aeoi_rot) lead_q <= p_lvl + LW'(1);
    end
  end

  assign vector = {base, ack_hit ? p_lvl : {LW{1'b1}}};

  always_comb begin
    if (addr)               rdata = mask_q;
    else if (poll)          rdata = {beats, {(N-1-LW){1'b0}}, beats ? p_lvl : {LW{1'b0}}};
    else if (rsel == SRC_SRV) rdata = isr_q;
    else                    rdata = irr;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
`timescale 1ns/1ps
module irq_ctrl_chk #(
  parameter int N  = 8,
  parameter int LW = $clog2(N)
) (
  input logic         clk,
  input logic         rst_n,
  input logic         addr,
  input logic         wr,
  input logic [N-1:0] wdata,
  input logic         ack,
  input logic         intr,
  input logic [N-1:0] vector,
  input logic [N-1:0] mask,
  input logic [N-1:0] isr,
  input logic         running,
  input logic         aeoi
);
  assert_restart_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr && wdata[4]) |=> (mask == '0 && isr == '0 && !intr));

  assert_quiet_in_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !intr);

  assert_mask_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr && addr) |=> (mask == $past(wdata)));

  assert_ack_marks_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && intr && !aeoi && !wr) |=> isr[$past(vector[LW-1:0])]);

  assert_spurious_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && running && !intr) |-> (vector[LW-1:0] == {LW{1'b1}}));

  assert_spurious_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && running && !intr && !wr) |=> $stable(isr));

  assert_auto_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && running && aeoi && !wr) |=> (isr == $past(isr)));
endmodule

bind irq_ctrl_core irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata), .ack(ack),
  .intr(intr), .vector(vector), .mask(mask_q), .isr(isr_q),
  .running(running), .aeoi(aeoi)
);

// File: tb/sim_irq_ctrl_core.sv
`timescale 1ns/1ps
module sim_irq_ctrl_core;
  logic       clk = 1'b0, rst_n = 1'b0, addr = 1'b0, wr = 1'b0, rd = 1'b0, ack = 1'b0;
  logic [7:0] wdata = 8'h00, irq_in = 8'h00;
  wire  [7:0] rdata, vector;
  wire        intr;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  irq_ctrl_core u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
    .rdata(rdata), .irq_in(irq_in), .intr(intr), .ack(ack), .vector(vector)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic chk_intr(input string req, input logic exp);
    #1;
    chk(req, "intr", {7'd0, intr}, {7'd0, exp});
  endtask

  task automatic wreg(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic ackp(output logic [7:0] v);
    @(negedge clk); ack = 1'b1;
    #1 v = vector;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic setirq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] w1, input logic [7:0] w2, input logic [7:0] w4);
    wreg(1'b0, w1);
    wreg(1'b1, w2);
    if (!w1[1]) wreg(1'b1, 8'h00);
    if (w1[0])  wreg(1'b1, w4);
  endtask

  function automatic logic [2:0] lowest(input logic [7:0] x);
    logic [2:0] r = 3'd0;
    for (int i = 7; i >= 0; i--) if (x[i]) r = 3'(i);
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, r, bitm, rest;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_intr("R1", 1'b0);
    rreg(1'b1, r); chk("R1", "mask after reset", r, 8'h00);
    rreg(1'b0, r); chk("R1", "request reg after reset", r, 8'h00);
    // R2 nothing works before setup
    setirq(8'h01);
    chk_intr("R2", 1'b0);
    ackp(v); chk("R2", "ack before setup", v, 8'h07);
    wreg(1'b1, 8'h55);
    rreg(1'b1, r); chk("R2", "mask write before setup", r, 8'h00);
    setirq(8'h00);

    // Sweep every request pattern, edge mode, fixed priority: R4 R5 R6 R7 R10
    for (int p = 1; p < 256; p++) begin
      setup(8'h13, 8'h40, 8'h01);
      setirq(8'(p));
      chk_intr("R5", 1'b1);
      rreg(1'b0, r); chk("R4", "edge capture", r, 8'(p));
      bitm = 8'h01 << lowest(8'(p));
      rest = 8'(p) & ~bitm;
      ackp(v); chk("R6", "vector", v, {5'b01000, lowest(8'(p))});
      rreg(1'b0, r); chk("R6", "edge request cleared", r, rest);
      wreg(1'b0, 8'h0B);
      rreg(1'b0, r); chk("R10", "in-service select", r, bitm);
      chk_intr("R5", 1'b0);
      wreg(1'b0, 8'h20);
      rreg(1'b0, r); chk("R7", "nonspecific eoi", r, 8'h00);
      chk_intr("R5", rest != 8'h00);
      setirq(8'h00);
    end

    // Sweep every mask value, level mode: R3 R4 R5 R6
    setup(8'h1B, 8'h40, 8'h01);
    setirq(8'hFF);
    for (int m = 0; m < 256; m++) begin
      wreg(1'b1, 8'(m));
      rreg(1'b1, r); chk("R3", "mask readback", r, 8'(m));
      rreg(1'b0, r); chk("R4", "masked still recorded", r, 8'hFF);
      chk_intr("R5", m != 255);
      ackp(v);
      chk("R6", "masked vector", v, (m == 255) ? 8'h47 : {5'b01000, lowest(~8'(m))});
      wreg(1'b0, 8'h20);
    end
    setirq(8'h00);
    rreg(1'b0, r); chk("R4", "level follows input", r, 8'h00);
    wreg(1'b1, 8'h00);

    // Rotation R8
    setirq(8'hFF);
    for (int k = 0; k < 10; k++) begin
      ackp(v); chk("R8", "rotating eoi order", v, {5'b01000, 3'(k % 8)});
      wreg(1'b0, 8'hA0);
    end
    for (int l = 0; l < 8; l++) begin
      wreg(1'b0, 8'hC0 | 8'(l));
      ackp(v); chk("R8", "set priority", v, {5'b01000, 3'((l + 1) % 8)});
      wreg(1'b0, 8'h60 | 8'((l + 1) % 8));
    end
    wreg(1'b0, 8'h0B);
    rreg(1'b0, r); chk("R7", "specific eoi leaves none", r, 8'h00);

    // Automatic end of interrupt R9
    setup(8'h1B, 8'h40, 8'h03);
    setirq(8'hFF);
    ackp(v); chk("R9", "auto eoi vector", v, 8'h40);
    wreg(1'b0, 8'h0B);
    rreg(1'b0, r); chk("R9", "auto eoi leaves no service", r, 8'h00);
    chk_intr("R9", 1'b1);
    wreg(1'b0, 8'h80);
    for (int k = 0; k < 3; k++) begin
      ackp(v); chk("R9", "auto rotate", v, 8'h40 | 8'(k));
    end
    wreg(1'b0, 8'h00);
    ackp(v); chk("R9", "auto rotate off", v, 8'h43);
    ackp(v); chk("R9", "auto rotate off again", v, 8'h43);

    // Nesting and special mask: R5 R7 R10 R12
    setirq(8'h00);
    setup(8'h13, 8'h40, 8'h01);
    setirq(8'h08);
    ackp(v); chk("R6", "level 3", v, 8'h43);
    setirq(8'h28);
    chk_intr("R5", 1'b0);
    setirq(8'h2A);
    chk_intr("R5", 1'b1);
    ackp(v); chk("R6", "nested level 1", v, 8'h41);
    wreg(1'b0, 8'h0B);
    rreg(1'b0, r); chk("R6", "two in service", r, 8'h0A);
    wreg(1'b0, 8'h20);
    rreg(1'b0, r); chk("R7", "best in service cleared", r, 8'h08);
    chk_intr("R5", 1'b0);
    wreg(1'b1, 8'h08);
    wreg(1'b0, 8'h68);
    chk_intr("R12", 1'b1);
    wreg(1'b0, 8'h48);
    chk_intr("R12", 1'b0);
    wreg(1'b1, 8'h00);
    wreg(1'b0, 8'h63);
    rreg(1'b0, r); chk("R10", "select held through mask commands", r, 8'h00);
    chk_intr("R7", 1'b1);
    ackp(v); chk("R6", "level 5", v, 8'h45);
    wreg(1'b0, 8'h65);

    // Special fully nested R13
    setirq(8'h00);
    setup(8'h13, 8'h40, 8'h11);
    setirq(8'h08);
    ackp(v);
    setirq(8'h00);
    setirq(8'h08);
    chk_intr("R13", 1'b1);
    setirq(8'h00);
    setup(8'h13, 8'h40, 8'h01);
    setirq(8'h08);
    ackp(v);
    setirq(8'h00);
    setirq(8'h08);
    chk_intr("R13", 1'b0);

    // Poll R11
    setirq(8'h00);
    setup(8'h13, 8'h40, 8'h01);
    wreg(1'b0, 8'h0C);
    rreg(1'b0, r); chk("R11", "poll empty", r, 8'h00);
    setirq(8'h30);
    wreg(1'b0, 8'h0C);
    rreg(1'b0, r); chk("R11", "poll word", r, 8'h84);
    wreg(1'b0, 8'h0B);
    rreg(1'b0, r); chk("R11", "poll serviced", r, 8'h10);
    rreg(1'b0, r); chk("R10", "select held", r, 8'h10);
    wreg(1'b0, 8'h0A);
    rreg(1'b0, r); chk("R10", "request select", r, 8'h20);
    wreg(1'b0, 8'h0B);
    wreg(1'b0, 8'h08);
    rreg(1'b0, r); chk("R10", "0x leaves select", r, 8'h10);

    // Setup paths R2 R1 R3
    setirq(8'h00);
    wreg(1'b0, 8'h11);
    wreg(1'b1, 8'h48);
    wreg(1'b1, 8'h04);
    rreg(1'b1, r); chk("R2", "cascade word not mask", r, 8'h00);
    wreg(1'b1, 8'h01);
    rreg(1'b1, r); chk("R2", "mode word not mask", r, 8'h00);
    wreg(1'b1, 8'hF0);
    rreg(1'b1, r); chk("R3", "mask after full setup", r, 8'hF0);
    wreg(1'b0, 8'h12);
    wreg(1'b1, 8'h50);
    rreg(1'b1, r); chk("R1", "restart clears mask", r, 8'h00);
    wreg(1'b1, 8'h3C);
    rreg(1'b1, r); chk("R2", "no mode word", r, 8'h3C);
    setirq(8'h40);
    ackp(v); chk("R2", "base word", v, 8'h56);
    setirq(8'h00);
    wreg(1'b0, 8'h13);
    setirq(8'h01);
    chk_intr("R2", 1'b0);
    wreg(1'b0, 8'h0B);
    wreg(1'b1, 8'h40);
    wreg(1'b1, 8'h01);
    chk_intr("R2", 1'b1);
    rreg(1'b0, r); chk("R2", "command during setup ignored", r, 8'h01);
    ackp(v); chk("R6", "after setup", v, 8'h40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule